// File: doc/BRIEF.md
# Power Mode Sequencer

This block steps a small system-on-chip through five power modes: full-speed run, a half-rate slow mode, idle, sleep and deep sleep. Software picks a mode by writing a three-bit code to a mode port. To reach idle, the sequencer asks the system bus for mastership. Sleep can only be entered once that mastership is held. On entry to sleep it raises the SDRAM self-refresh request and gates the internal clocks. Deep sleep also switches off the main oscillator and the PLL.

Three level-sensitive wake sources bring the system back from sleep or deep sleep: a user key, an RTC alarm and a modem ring indicator. Each wake source passes through a two-flop synchronizer. In deep sleep the sequencer advances only on a slow tick, taken as every eighth pulse of the 32 kHz RTC clock strobe. When it leaves deep sleep it re-enables the oscillator and PLL, then waits a programmable number of slow ticks for lock before it returns to idle. While idle, an interrupt or a DMA bus request hands the bus back and resumes the mode that was left. After a wake-up, that mode is always slow.

The oscillators, PLL, SDRAM controller, RTC and bus arbiter are outside the block. They appear only as handshake signals.

Top module: `pm_mode_ctl`

## Requirements
- R1: While reset is active, and after it is released, the outputs are: mode_o=0, bus_req=0, sdram_sr_req=0, clk_gate_off=0, osc_en=1, pll_en=1, cpu_half_rate=0, ctl_slow_clk=0 and wake_ack=0.
- R2: The mode codes are 0=run, 1=slow, 2=idle, 3=sleep and 4=deep sleep. In run or slow, a write of code 0 or 1 sets mode_o to that code after the next clock edge. cpu_half_rate is 1 exactly while mode_o=1.
- R3: In run or slow, a write of code 2 gives mode_o=2 and bus_req=1 after the next clock edge.
- R4: While mode_o=2, irq, fiq or dma_req high at a clock edge gives bus_req=0 after that edge. mode_o then returns to the code (0 or 1) held before idle.
- R5: A code 3 write in idle gives mode_o=3, sdram_sr_req=1 and clk_gate_off=1. If bus_gnt has not yet been seen, the request waits, and mode_o becomes 3 after the first edge with bus_gnt high.
- R6: The following writes leave mode_o unchanged: codes 3 to 7 in run or slow, codes 0, 1 and 4 in idle. Wake inputs outside sleep and deep sleep also leave mode_o unchanged.
- R7: A code 4 write in sleep gives mode_o=4, osc_en=0, pll_en=0, ctl_slow_clk=1 and sdram_sr_req=1 after the next edge.
- R8: In sleep, any of the three wake bits (bit 0 key, bit 1 RTC alarm, bit 2 ring) holds mode_o=3 through two clock edges. After the third edge mode_o=2, sdram_sr_req=0 and clk_gate_off=0, and wake_ack pulses high for exactly one cycle.
- R9: In deep sleep, state changes only on slow ticks. A slow tick is the 8th, 16th, ... rtc_tick pulse counted since reset. A held wake input re-enables osc_en and pll_en, with a wake_ack pulse, on the third slow tick.
- R10: After the oscillator and PLL are re-enabled, mode_o stays 4 for lock_wait+1 slow ticks. It then becomes 2, with sdram_sr_req=0, ctl_slow_clk=0 and bus_req=1.
- R11: Release from an idle reached by a wake-up gives mode_o=1.
- R12: In idle, an irq, fiq or dma_req in the same cycle as a code 3 write wins, and mode_o returns to the code held before idle. A release while a sleep request is still pending cancels that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | One-cycle strobe per 32 kHz RTC period |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | Requested mode code |
| bus_gnt | input | 1 | Bus grant from arbiter |
| irq | input | 1 | Normal CPU interrupt |
| fiq | input | 1 | Fast CPU interrupt |
| dma_req | input | 1 | Peripheral DMA bus request |
| wake_in | input | 3 | Wake levels: key, RTC alarm, ring |
| lock_wait | input | 8 | Lock wait length in slow ticks, minus one |
| bus_req | output | 1 | Bus mastership request |
| cpu_half_rate | output | 1 | CPU runs from the half-rate bus clock |
| clk_gate_off | output | 1 | Internal clocks gated off |
| sdram_sr_req | output | 1 | SDRAM self-refresh request |
| osc_en | output | 1 | Main oscillator enable |
| pll_en | output | 1 | PLL enable |
| ctl_slow_clk | output | 1 | Sequencer running from divided RTC clock |
| wake_ack | output | 1 | One-cycle acceptance of a wake event |
| mode_o | output | 3 | Current mode code |

## Verification
Two events can land on the same edge: an idle release (interrupt or DMA) and a software step deeper into sleep. The bench provokes the collision twice. First it raises irq in the cycle that writes code 3 in granted idle. Then it raises fiq together with bus_gnt while a sleep request is still pending. In both cases the result passes only if mode_o goes back to run with bus_req low, and if the next idle entry stays in idle rather than sleep.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_SLOW  = 3'd1,
    ST_IDREQ = 3'd2,
    ST_IDLE  = 3'd3,
    ST_SLEEP = 3'd4,
    ST_DEEP  = 3'd5,
    ST_LOCK  = 3'd6
  } pmc_state_e;

  localparam logic [2:0] MC_RUN   = 3'd0;
  localparam logic [2:0] MC_SLOW  = 3'd1;
  localparam logic [2:0] MC_IDLE  = 3'd2;
  localparam logic [2:0] MC_SLEEP = 3'd3;
  localparam logic [2:0] MC_DEEP  = 3'd4;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= 2'b00;
    else         sh_q <= {sh_q[0], 1'b1};
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/pmc_wake_sync.sv
module pmc_wake_sync #(
  parameter int NWAKE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [NWAKE-1:0] wake_async,
  output logic             wake_any
);
  logic [NWAKE-1:0] stage2;

  for (genvar g = 0; g < NWAKE; g++) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else if (ce) begin
        s1_q <= wake_async[g];
        s2_q <= s1_q;
      end
    end
    assign stage2[g] = s2_q;
  end

  assign wake_any = |stage2;
endmodule

// File: rtl/pmc_tick_div.sv
module pmc_tick_div #(
  parameter int DIV_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rtc_tick,
  output logic slow_tick
);
  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (rtc_tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign slow_tick = rtc_tick & (&cnt_q);
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              mode_wr,
  input  logic [2:0]        mode_wdata,
  input  logic              bus_gnt,
  input  logic              rel_req,
  input  logic              wake_any,
  input  logic [LOCK_W-1:0] lock_wait,
  output pmc_state_e        state_o,
  output logic              wake_ack
);
  pmc_state_e        state_q, state_d;
  logic              ret_slow_q, ret_slow_d;
  logic              pend_q, pend_d;
  logic [LOCK_W-1:0] cnt_q, cnt_d;
  logic              ack_q, accept_wake;
  logic              wr_sleep, wr_deep;
  pmc_state_e        ret_state;

  assign wr_sleep  = mode_wr && (mode_wdata == MC_SLEEP);
  assign wr_deep   = mode_wr && (mode_wdata == MC_DEEP);
  assign ret_state = ret_slow_q ? ST_SLOW : ST_RUN;

  always_comb begin
    state_d     = state_q;
    ret_slow_d  = ret_slow_q;
    pend_d      = pend_q;
    cnt_d       = cnt_q;
    accept_wake = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (mode_wr && mode_wdata == MC_SLOW) state_d = ST_SLOW;
        else if (mode_wr && mode_wdata == MC_IDLE) begin
          state_d    = ST_IDREQ;
          ret_slow_d = 1'b0;
          pend_d     = 1'b0;
        end
      end
      ST_SLOW: begin
        if (mode_wr && mode_wdata == MC_RUN) state_d = ST_RUN;
        else if (mode_wr && mode_wdata == MC_IDLE) begin
          state_d    = ST_IDREQ;
          ret_slow_d = 1'b1;
          pend_d     = 1'b0;
        end
      end
      ST_IDREQ: begin
        if (rel_req) begin
          state_d = ret_state;
          pend_d  = 1'b0;
        end else if (bus_gnt) begin
          state_d = (pend_q || wr_sleep) ? ST_SLEEP : ST_IDLE;
          pend_d  = 1'b0;
        end else if (wr_sleep) begin
          pend_d = 1'b1;
        end
      end
      ST_IDLE: begin
        if (rel_req)       state_d = ret_state;
        else if (wr_sleep) state_d = ST_SLEEP;
      end
      ST_SLEEP: begin
        if (wake_any) begin
          state_d     = ST_IDLE;
          ret_slow_d  = 1'b1;
          accept_wake = 1'b1;
        end else if (wr_deep) begin
          state_d = ST_DEEP;
        end
      end
      ST_DEEP: begin
        if (wake_any) begin
          state_d     = ST_LOCK;
          cnt_d       = '0;
          accept_wake = 1'b1;
        end
      end
      ST_LOCK: begin
        if (cnt_q == lock_wait) begin
          state_d    = ST_IDLE;
          ret_slow_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      ret_slow_q <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
    end else if (ce) begin
      state_q    <= state_d;
      ret_slow_q <= ret_slow_d;
      pend_q     <= pend_d;
      cnt_q      <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= ce & accept_wake;
  end

  assign state_o  = state_q;
  assign wake_ack = ack_q;
endmodule

// File: rtl/pm_mode_ctl.sv
module pm_mode_ctl
  import pmc_pkg::*;
#(
  parameter int NWAKE    = 3,
  parameter int DIV_LOG2 = 3,
  parameter int LOCK_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rtc_tick,
  input  logic              mode_wr,
  input  logic [2:0]        mode_wdata,
  input  logic              bus_gnt,
  input  logic              irq,
  input  logic              fiq,
  input  logic              dma_req,
  input  logic [NWAKE-1:0]  wake_in,
  input  logic [LOCK_W-1:0] lock_wait,
  output logic              bus_req,
  output logic              cpu_half_rate,
  output logic              clk_gate_off,
  output logic              sdram_sr_req,
  output logic              osc_en,
  output logic              pll_en,
  output logic              ctl_slow_clk,
  output logic              wake_ack,
  output logic [2:0]        mode_o
);
  logic       srst_n, slow_tick, wake_any, ce, slow_domain;
  pmc_state_e state;

  pmc_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  pmc_tick_div #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk(clk), .rst_n(srst_n), .rtc_tick(rtc_tick), .slow_tick(slow_tick)
  );

  assign slow_domain = (state == ST_DEEP) || (state == ST_LOCK);
  assign ce          = slow_domain ? slow_tick : 1'b1;

  pmc_wake_sync #(.NWAKE(NWAKE)) u_wake (
    .clk(clk), .rst_n(srst_n), .ce(ce), .wake_async(wake_in), .wake_any(wake_any)
  );

  pmc_seq #(.LOCK_W(LOCK_W)) u_seq (
    .clk(clk), .rst_n(srst_n), .ce(ce), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .bus_gnt(bus_gnt), .rel_req(irq | fiq | dma_req), .wake_any(wake_any),
    .lock_wait(lock_wait), .state_o(state), .wake_ack(wake_ack)
  );

  always_comb begin
    unique case (state)
      ST_RUN:            mode_o = MC_RUN;
      ST_SLOW:           mode_o = MC_SLOW;
      ST_IDREQ, ST_IDLE: mode_o = MC_IDLE;
      ST_SLEEP:          mode_o = MC_SLEEP;
      default:           mode_o = MC_DEEP;
    endcase
  end

  assign bus_req       = (state != ST_RUN) && (state != ST_SLOW);
  assign sdram_sr_req  = (state == ST_SLEEP) || slow_domain;
  assign clk_gate_off  = sdram_sr_req;
  assign osc_en        = (state != ST_DEEP);
  assign pll_en        = (state != ST_DEEP);
  assign ctl_slow_clk  = slow_domain;
  assign cpu_half_rate = (state == ST_SLOW);
endmodule

// File: rtl/pm_mode_ctl_chk.sv
module pm_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq,
  input logic       fiq,
  input logic       dma_req,
  input logic       slow_tick,
  input logic       bus_req,
  input logic       cpu_half_rate,
  input logic       clk_gate_off,
  input logic       sdram_sr_req,
  input logic       osc_en,
  input logic       pll_en,
  input logic       wake_ack,
  input logic [2:0] mode_o
);
  AST_SR_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    sdram_sr_req |-> (bus_req && clk_gate_off)); // R5
  AST_SLEEP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd3 && $past(mode_o) != 3'd3) |-> ($past(mode_o) == 3'd2)); // R5
  AST_DEEP_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && $past(mode_o) != 3'd4) |-> ($past(mode_o) == 3'd3)); // R7
  AST_OSC_OFF_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en || !pll_en) |-> (sdram_sr_req && mode_o == 3'd4)); // R7
  AST_HALF_IN_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_half_rate |-> (mode_o == 3'd1)); // R2
  AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd2 && (irq || fiq || dma_req)) |=> !bus_req); // R4
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ack |=> !wake_ack); // R8
  AST_DEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd4 && !slow_tick) |=> $stable(mode_o)); // R9
endmodule

bind pm_mode_ctl pm_mode_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .fiq(fiq), .dma_req(dma_req),
  .slow_tick(slow_tick), .bus_req(bus_req), .cpu_half_rate(cpu_half_rate),
  .clk_gate_off(clk_gate_off), .sdram_sr_req(sdram_sr_req), .osc_en(osc_en),
  .pll_en(pll_en), .wake_ack(wake_ack), .mode_o(mode_o)
);

// File: tb/pm_mode_ctl_tb_top.sv
module pm_mode_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, rtc_tick, mode_wr, bus_gnt, irq, fiq, dma_req;
  logic [2:0] mode_wdata, wake_in;
  logic [7:0] lock_wait;
  logic       bus_req, cpu_half_rate, clk_gate_off, sdram_sr_req;
  logic       osc_en, pll_en, ctl_slow_clk, wake_ack;
  logic [2:0] mode_o;
  int         n_chk = 0, n_bad = 0, rtc_n = 0;

  always #2 clk = ~clk;

  pm_mode_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .mode_wr(mode_wr),
    .mode_wdata(mode_wdata), .bus_gnt(bus_gnt), .irq(irq), .fiq(fiq),
    .dma_req(dma_req), .wake_in(wake_in), .lock_wait(lock_wait),
    .bus_req(bus_req), .cpu_half_rate(cpu_half_rate), .clk_gate_off(clk_gate_off),
    .sdram_sr_req(sdram_sr_req), .osc_en(osc_en), .pll_en(pll_en),
    .ctl_slow_clk(ctl_slow_clk), .wake_ack(wake_ack), .mode_o(mode_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] c);
    mode_wr = 1'b1; mode_wdata = c;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic release_bus(int kind);
    irq = (kind == 0); fiq = (kind == 1); dma_req = (kind == 2);
    @(negedge clk);
    irq = 1'b0; fiq = 1'b0; dma_req = 1'b0;
  endtask

  task automatic slow_step();
    bit hit;
    do begin
      hit = ((rtc_n % 8) == 7);
      rtc_tick = 1'b1;
      @(negedge clk);
      rtc_tick = 1'b0;
      rtc_n++;
    end while (!hit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rtc_tick = 1'b0; mode_wr = 1'b0; mode_wdata = 3'd0;
    bus_gnt = 1'b0; irq = 1'b0; fiq = 1'b0; dma_req = 1'b0;
    wake_in = 3'd0; lock_wait = 8'd0;
    cyc(3);
    // R1 during and after reset
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 sr", int'(sdram_sr_req), 0);
    chk("R1 gate", int'(clk_gate_off), 0);
    chk("R1 osc", int'(osc_en), 1);
    chk("R1 pll", int'(pll_en), 1);
    chk("R1 half", int'(cpu_half_rate), 0);
    chk("R1 slowclk", int'(ctl_slow_clk), 0);
    chk("R1 ack", int'(wake_ack), 0);
    rst_n = 1'b1;
    cyc(4);
    chk("R1 mode after release", int'(mode_o), 0);

    // R2 R3 R4 R6: every code from run and from slow
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        wr(3'(s));
        chk("R2 start", int'(mode_o), s);
        chk("R2 half", int'(cpu_half_rate), s);
        wr(3'(c));
        if (c <= 1) begin
          chk("R2 switch", int'(mode_o), c);
          chk("R2 half after", int'(cpu_half_rate), c);
        end else if (c == 2) begin
          chk("R3 mode", int'(mode_o), 2);
          chk("R3 bus_req", int'(bus_req), 1);
          bus_gnt = 1'b1;
          cyc(1);
          chk("R3 idle held", int'(mode_o), 2);
          release_bus((s * 8 + c) % 3);
          chk("R4 return", int'(mode_o), s);
          chk("R4 bus_req", int'(bus_req), 0);
          bus_gnt = 1'b0;
        end else begin
          chk("R6 ignored", int'(mode_o), s);
        end
      end
    end
    wake_in = 3'b111;
    cyc(5);
    chk("R6 wake in slow", int'(mode_o), 1);
    wake_in = 3'b000;
    cyc(3);

    // R5 pending sleep
    wr(3'd0); wr(3'd2); wr(3'd3);
    cyc(2);
    chk("R5 pending", int'(mode_o), 2);
    chk("R5 pending sr", int'(sdram_sr_req), 0);
    bus_gnt = 1'b1;
    cyc(1);
    chk("R5 sleep", int'(mode_o), 3);
    chk("R5 sr", int'(sdram_sr_req), 1);
    chk("R5 gate", int'(clk_gate_off), 1);

    // R8 R11 R6: each wake source from sleep
    for (int b = 0; b < 3; b++) begin
      if (b != 0) begin
        wr(3'd0); wr(3'd2); cyc(1); wr(3'd3);
        chk("R5 sleep again", int'(mode_o), 3);
      end
      wake_in = 3'(1 << b);
      cyc(2);
      chk("R8 still sleep", int'(mode_o), 3);
      cyc(1);
      chk("R8 idle", int'(mode_o), 2);
      chk("R8 ack", int'(wake_ack), 1);
      chk("R8 sr off", int'(sdram_sr_req), 0);
      chk("R8 gate off", int'(clk_gate_off), 0);
      cyc(1);
      chk("R8 ack pulse", int'(wake_ack), 0);
      wake_in = 3'd0;
      wr(3'd4);
      chk("R6 deep in idle", int'(mode_o), 2);
      wr(3'd0);
      chk("R6 run in idle", int'(mode_o), 2);
      release_bus(b);
      chk("R11 slow", int'(mode_o), 1);
    end

    // R7 R9 R10 R11: deep sleep with lock waits 0..3
    for (int lw = 0; lw < 4; lw++) begin
      lock_wait = 8'(lw);
      wr(3'd0); wr(3'd2); cyc(1); wr(3'd3); wr(3'd4);
      chk("R7 mode", int'(mode_o), 4);
      chk("R7 osc", int'(osc_en), 0);
      chk("R7 pll", int'(pll_en), 0);
      chk("R7 slowclk", int'(ctl_slow_clk), 1);
      chk("R7 sr", int'(sdram_sr_req), 1);
      wake_in = 3'(1 << (lw % 3));
      cyc(3);
      chk("R9 fast edges ignored", int'(osc_en), 0);
      slow_step();
      chk("R9 tick1", int'(osc_en), 0);
      slow_step();
      chk("R9 tick2", int'(osc_en), 0);
      slow_step();
      chk("R9 tick3 osc", int'(osc_en), 1);
      chk("R9 tick3 pll", int'(pll_en), 1);
      chk("R9 tick3 ack", int'(wake_ack), 1);
      chk("R9 tick3 mode", int'(mode_o), 4);
      cyc(1);
      chk("R9 ack pulse", int'(wake_ack), 0);
      for (int j = 0; j <= lw; j++) begin
        slow_step();
        if (j < lw) chk("R10 locking", int'(mode_o), 4);
        else begin
          chk("R10 idle", int'(mode_o), 2);
          chk("R10 sr", int'(sdram_sr_req), 0);
          chk("R10 slowclk", int'(ctl_slow_clk), 0);
          chk("R10 bus", int'(bus_req), 1);
        end
      end
      wake_in = 3'd0;
      release_bus(lw % 3);
      chk("R11 slow after deep", int'(mode_o), 1);
    end

    // R12 same-cycle release versus sleep
    wr(3'd0); wr(3'd2); cyc(1);
    mode_wr = 1'b1; mode_wdata = 3'd3; irq = 1'b1;
    cyc(1);
    mode_wr = 1'b0; irq = 1'b0;
    chk("R12 irq wins", int'(mode_o), 0);
    chk("R12 sr", int'(sdram_sr_req), 0);
    chk("R12 bus", int'(bus_req), 0);
    bus_gnt = 1'b0;
    wr(3'd2); wr(3'd3);
    bus_gnt = 1'b1; fiq = 1'b1;
    cyc(1);
    fiq = 1'b0;
    chk("R12 pending dropped", int'(mode_o), 0);
    chk("R12 pending bus", int'(bus_req), 0);
    wr(3'd2); cyc(1);
    chk("R12 no stale sleep", int'(mode_o), 2);
    chk("R12 no stale sr", int'(sdram_sr_req), 0);
    release_bus(2);
    chk("R4 dma release", int'(mode_o), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule